// File: doc/BRIEF.md
# Battery and Mains Status Register Block

This block is a memory-mapped slave that tells a host processor what state the battery and the mains adapter are in. The host reads the values through a set of 32-bit registers. The values come from side-band inputs, each group paired with a change strobe, so that a surrounding environment or test harness can play the role of a user panel. Every change of battery or mains state sets a pending flag. One level-sensitive interrupt line is raised whenever a pending flag is also enabled.

The bus port is a simple register port. A request is one cycle of valid, with write, address and write data. The response comes exactly one cycle later: an acknowledge, an error flag and the read data.

Reading the interrupt status register hands back the pending flags masked by the enable flags. When that masked value is nonzero, the same access clears all pending flags. When it is zero, nothing is cleared. The reset values of the battery fields depend on a strap input that says whether a battery is fitted.

Top module: `batt_mmio`

## Requirements
- R1: Registers sit at byte offsets 0x00 interrupt status, 0x04 interrupt enable, 0x08 mains online, 0x0C charge state, 0x10 health, 0x14 battery present and 0x18 charge level. Each register reads back, zero-extended to 32 bits, the value most recently loaded into it.
- R2: While reset is held with the battery strap at 1, the block loads these values: mains online 1, charge state 1 (charging), health 1 (good), present 1 and level 50. It also loads interrupt enable 0 and no pending flags, so the interrupt line is low.
- R3: While reset is held with the battery strap at 0, the block loads these values: mains online 1, charge state 3 (not charging), health 3 (dead), present 0 and level 0.
- R4: A cycle with the battery strobe high loads charge state (0 unknown, 1 charging, 2 discharging, 3 not charging), health (0 unknown, 1 good, 2 overheating, 3 dead, 4 overvoltage, 5 unspecified failure), present and level, and sets pending bit 0. A cycle with the mains strobe high loads mains online and sets pending bit 1.
- R5: A level input above 100 is stored as 100, so the level register never exceeds 100.
- R6: A write to offset 0x04 stores write data bits [1:0] as the enable mask. Bit 0 enables the battery event and bit 1 the mains event. The mask reads back in bits [1:0], with the upper bits 0.
- R7: The interrupt output is high exactly when pending AND enable is nonzero. It changes in the cycle after the strobe, write or read that caused the change.
- R8: A read of offset 0x00 returns pending AND enable. If that value is nonzero, all pending flags clear and the interrupt drops in the next cycle. If it is zero, the pending flags are kept, and a later enable raises the interrupt.
- R9: A strobe in the same cycle as a clearing read of offset 0x00 leaves its pending flag set.
- R10: The following accesses return an error with read data 0 and change no register: an offset that is not word aligned, an offset above 0x18, and a write to any offset other than 0x04.
- R11: Each access cycle is acknowledged exactly one cycle later, and no acknowledge appears without an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| batt_fitted | input | 1 | Strap: 1 when a battery is fitted, sampled during reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Response valid, one cycle after bus_valid |
| bus_err | output | 1 | Response is an error |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| env_batt_upd | input | 1 | Battery state change strobe |
| env_chg_state | input | 2 | New charge state |
| env_health | input | 3 | New health code |
| env_present | input | 1 | New battery present flag |
| env_level | input | 7 | New charge level, clamped to 100 |
| env_mains_upd | input | 1 | Mains state change strobe |
| env_mains_on | input | 1 | New mains online flag |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the strap is held steady around reset. They also assume that the strobes and bus inputs are sampled only on clock edges, and that a health code above 5 is never presented. The bench drives every input at the falling edge and draws health codes only from 0 to 5. It keeps the strap constant inside each reset phase. The level input is drawn over its full 7-bit range, so the clamp is exercised on purpose rather than excluded.

// File: rtl/batt_pkg.sv
package batt_pkg;
    localparam int LVL_W    = 7;
    localparam int LVL_MAX  = 100;
    localparam int LVL_DEF  = 50;
    localparam int NUM_REGS = 7;

    localparam logic [1:0] CHG_CHARGING = 2'd1;
    localparam logic [1:0] CHG_IDLE     = 2'd3;
    localparam logic [2:0] HL_GOOD      = 3'd1;
    localparam logic [2:0] HL_DEAD      = 3'd3;

    typedef enum logic [2:0] {
        SEL_IST  = 3'd0,
        SEL_IEN  = 3'd1,
        SEL_AC   = 3'd2,
        SEL_CHG  = 3'd3,
        SEL_HLTH = 3'd4,
        SEL_PRES = 3'd5,
        SEL_LVL  = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic             mains;
        logic [1:0]       chg;
        logic [2:0]       hlth;
        logic             pres;
        logic [LVL_W-1:0] lvl;
    } batt_state_t;

    typedef struct packed {
        logic [1:0] pend;
        logic [1:0] en;
    } irq_state_t;
endpackage

// File: rtl/batt_addr_decode.sv
module batt_addr_decode
    import batt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              rd_ok,
    output logic              en_wr,
    output logic              bad
);
    localparam int WORD_W = ADDR_W - 2;

    logic [NUM_REGS-1:0] hit;
    logic                aligned;

    assign aligned = (addr[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i] = aligned && (addr[ADDR_W-1:2] == WORD_W'(i));
    end

    always_comb begin
        sel = SEL_NONE;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) sel = reg_sel_e'(i[2:0]);
        end
    end

    assign rd_ok = valid && !write && (sel != SEL_NONE);
    assign en_wr = valid && write && (sel == SEL_IEN);
    assign bad   = valid && !rd_ok && !en_wr;
endmodule

// File: rtl/batt_state_regs.sv
module batt_state_regs
    import batt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             batt_fitted,
    input  logic             batt_upd,
    input  logic [1:0]       chg_in,
    input  logic [2:0]       hlth_in,
    input  logic             pres_in,
    input  logic [LVL_W-1:0] lvl_in,
    input  logic             mains_upd,
    input  logic             mains_in,
    output batt_state_t      st_q
);
    batt_state_t st_d;
    logic [LVL_W-1:0] lvl_clamped;

    assign lvl_clamped = (lvl_in > LVL_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : lvl_in;

    always_comb begin
        st_d = st_q;
        if (batt_upd) begin
            st_d.chg  = chg_in;
            st_d.hlth = hlth_in;
            st_d.pres = pres_in;
            st_d.lvl  = lvl_clamped;
        end
        if (mains_upd) st_d.mains = mains_in;
        if (!rst_n) begin
            st_d.mains = 1'b1;
            if (batt_fitted) begin
                st_d.chg  = CHG_CHARGING;
                st_d.hlth = HL_GOOD;
                st_d.pres = 1'b1;
                st_d.lvl  = LVL_W'(LVL_DEF);
            end else begin
                st_d.chg  = CHG_IDLE;
                st_d.hlth = HL_DEAD;
                st_d.pres = 1'b0;
                st_d.lvl  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    p_lvl_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LVL_W'(LVL_MAX));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_upd |=> $stable(st_q.lvl) && $stable(st_q.chg) && $stable(st_q.hlth));

    p_mains_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mains_upd |=> st_q.mains == $past(mains_in));
endmodule

// File: rtl/batt_irq_ctrl.sv
module batt_irq_ctrl
    import batt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       batt_evt,
    input  logic       mains_evt,
    input  logic       en_wr,
    input  logic [1:0] en_wdata,
    input  logic       ist_rd,
    output logic [1:0] vis,
    output logic [1:0] en_q,
    output logic       irq
);
    irq_state_t s_d, s_q;
    logic       clr;

    assign vis  = s_q.pend & s_q.en;
    assign en_q = s_q.en;
    assign irq  = |vis;
    assign clr  = ist_rd && (vis != 2'b00);

    always_comb begin
        s_d      = s_q;
        s_d.pend = (clr ? 2'b00 : s_q.pend) | {mains_evt, batt_evt};
        if (en_wr) s_d.en = en_wdata;
        if (!rst_n) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !batt_evt && !mains_evt |=> s_q.pend == 2'b00 && !irq);

    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ist_rd && mains_evt |=> s_q.pend[1]);

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(batt_evt || mains_evt || en_wr));

    p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(s_q.en));
endmodule

// File: rtl/batt_mmio.sv
module batt_mmio
    import batt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              batt_fitted,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              env_batt_upd,
    input  logic [1:0]        env_chg_state,
    input  logic [2:0]        env_health,
    input  logic              env_present,
    input  logic [LVL_W-1:0]  env_level,
    input  logic              env_mains_upd,
    input  logic              env_mains_on,
    output logic              irq
);
    typedef struct packed {
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    reg_sel_e    sel;
    logic        rd_ok, en_wr, bad, ist_rd;
    logic [1:0]  vis, en_q;
    batt_state_t st_q;
    resp_t       resp_d, resp_q;

    batt_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .sel   (sel),
        .rd_ok (rd_ok),
        .en_wr (en_wr),
        .bad   (bad)
    );

    batt_state_regs u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .batt_fitted (batt_fitted),
        .batt_upd    (env_batt_upd),
        .chg_in      (env_chg_state),
        .hlth_in     (env_health),
        .pres_in     (env_present),
        .lvl_in      (env_level),
        .mains_upd   (env_mains_upd),
        .mains_in    (env_mains_on),
        .st_q        (st_q)
    );

    assign ist_rd = rd_ok && (sel == SEL_IST);

    batt_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .batt_evt  (env_batt_upd),
        .mains_evt (env_mains_upd),
        .en_wr     (en_wr),
        .en_wdata  (bus_wdata[1:0]),
        .ist_rd    (ist_rd),
        .vis       (vis),
        .en_q      (en_q),
        .irq       (irq)
    );

    always_comb begin
        resp_d       = '0;
        resp_d.ack   = bus_valid;
        resp_d.err   = bad;
        if (rd_ok) begin
            unique case (sel)
                SEL_IST:  resp_d.rdata = DATA_W'(vis);
                SEL_IEN:  resp_d.rdata = DATA_W'(en_q);
                SEL_AC:   resp_d.rdata = DATA_W'(st_q.mains);
                SEL_CHG:  resp_d.rdata = DATA_W'(st_q.chg);
                SEL_HLTH: resp_d.rdata = DATA_W'(st_q.hlth);
                SEL_PRES: resp_d.rdata = DATA_W'(st_q.pres);
                SEL_LVL:  resp_d.rdata = DATA_W'(st_q.lvl);
                default:  resp_d.rdata = '0;
            endcase
        end
        if (!rst_n) resp_d = '0;
    end

    always_ff @(posedge clk) begin
        resp_q <= resp_d;
    end

    assign bus_ack   = resp_q.ack;
    assign bus_err   = resp_q.err;
    assign bus_rdata = resp_q.rdata;

    p_ack_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_ack);

    p_no_spurious_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_ack);

    p_err_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack && bus_rdata == '0);

    p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && bus_addr != ADDR_W'(4) |=> bus_err);
endmodule

// File: tb/batt_mmio_test.sv
module batt_mmio_test;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              batt_fitted = 1'b1;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_ack, bus_err, irq;
    logic [DATA_W-1:0] bus_rdata;
    logic              env_batt_upd = 1'b0, env_present = 1'b0;
    logic [1:0]        env_chg_state = '0;
    logic [2:0]        env_health = '0;
    logic [6:0]        env_level = '0;
    logic              env_mains_upd = 1'b0, env_mains_on = 1'b0;

    int n_checks = 0, n_bad = 0;
    bit finished = 0;

    logic [1:0] m_pend, m_en, m_chg;
    logic [2:0] m_hl;
    logic [6:0] m_lvl;
    logic       m_ac, m_pres;

    always #(CLK_P/2) clk = ~clk;

    batt_mmio #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .batt_fitted(batt_fitted),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .env_batt_upd(env_batt_upd),
        .env_chg_state(env_chg_state), .env_health(env_health),
        .env_present(env_present), .env_level(env_level),
        .env_mains_upd(env_mains_upd), .env_mains_on(env_mains_on), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] clamp(logic [6:0] v);
        return (v > 7'd100) ? 7'd100 : v;
    endfunction

    function automatic logic exp_err(logic w, logic [7:0] a);
        if (a[1:0] != 2'b00 || a > 8'h18) return 1'b1;
        return w && a != 8'h04;
    endfunction

    function automatic logic [31:0] exp_val(logic [7:0] a);
        case (a)
            8'h00: return 32'(m_pend & m_en);
            8'h04: return 32'(m_en);
            8'h08: return 32'(m_ac);
            8'h0C: return 32'(m_chg);
            8'h10: return 32'(m_hl);
            8'h14: return 32'(m_pres);
            8'h18: return 32'(m_lvl);
            default: return 32'h0;
        endcase
    endfunction

    task automatic do_reset(logic strap, string req);
        @(negedge clk);
        batt_fitted = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pend = 0; m_en = 0; m_ac = 1;
        if (strap) begin m_chg = 1; m_hl = 1; m_pres = 1; m_lvl = 50; end
        else       begin m_chg = 3; m_hl = 3; m_pres = 0; m_lvl = 0;  end
        chk({req, " irq after reset"}, 32'(irq), 0);
    endtask

    // one bus access, optional strobes in the same cycle; checks response and irq
    task automatic access(logic w, logic [7:0] a, logic [31:0] d, string req,
                          logic bu = 0, logic mu = 0);
        logic e;
        logic [31:0] v;
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
        env_batt_upd = bu; env_mains_upd = mu;
        e = exp_err(w, a);
        v = (e || w) ? 32'h0 : exp_val(a);
        if (!e && !w && a == 8'h00 && v != 0) m_pend = 2'b00;
        if (!e && w) m_en = d[1:0];
        if (bu) begin
            m_pend[0] = 1; m_chg = env_chg_state; m_hl = env_health;
            m_pres = env_present; m_lvl = clamp(env_level);
        end
        if (mu) begin m_pend[1] = 1; m_ac = env_mains_on; end
        @(negedge clk);
        bus_valid = 1'b0; env_batt_upd = 0; env_mains_upd = 0;
        chk({req, " ack"}, 32'(bus_ack), 1);
        chk({req, " err"}, 32'(bus_err), 32'(e));
        chk({req, " rdata"}, bus_rdata, v);
        chk({req, " irq"}, 32'(irq), 32'(|(m_pend & m_en)));
    endtask

    task automatic batt_event(logic [1:0] c, logic [2:0] h, logic p, logic [6:0] l, string req);
        env_batt_upd = 1; env_chg_state = c; env_health = h; env_present = p; env_level = l;
        m_pend[0] = 1; m_chg = c; m_hl = h; m_pres = p; m_lvl = clamp(l);
        @(negedge clk);
        env_batt_upd = 0;
        chk({req, " irq"}, 32'(irq), 32'(|(m_pend & m_en)));
        chk({req, " no ack"}, 32'(bus_ack), 0);
    endtask

    task automatic mains_event(logic on, string req);
        env_mains_upd = 1; env_mains_on = on;
        m_pend[1] = 1; m_ac = on;
        @(negedge clk);
        env_mains_upd = 0;
        chk({req, " irq"}, 32'(irq), 32'(|(m_pend & m_en)));
    endtask

    task automatic read_all(string req);
        for (int i = 1; i < 7; i++) access(0, 8'(i * 4), 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R3: no battery fitted
        do_reset(0, "R3");
        read_all("R3 defaults");
        // R2: battery fitted
        do_reset(1, "R2");
        read_all("R2 defaults");
        access(0, 8'h00, 0, "R2 status idle");
        // R6: enable write and readback
        access(1, 8'h04, 32'hFFFF_FFFE, "R6 write");
        access(0, 8'h04, 0, "R6 readback");
        // R4, R7: battery event with enable bit0 low -> no irq
        batt_event(2, 4, 1, 7'd77, "R4 batt evt masked");
        // R8: masked read returns 0, keeps pending
        access(0, 8'h00, 0, "R8 zero read keeps");
        access(1, 8'h04, 32'h1, "R7 enable raises irq");
        access(0, 8'h00, 0, "R8 clearing read");
        access(0, 8'h00, 0, "R8 after clear");
        // R5: clamp
        batt_event(1, 5, 0, 7'd127, "R5 clamp");
        access(0, 8'h18, 0, "R5 level");
        batt_event(1, 5, 0, 7'd100, "R5 boundary");
        access(0, 8'h18, 0, "R5 level 100");
        access(0, 8'h00, 0, "R8 clear");
        // R4 mains strobe
        access(1, 8'h04, 32'h3, "R6 enable both");
        mains_event(0, "R4 mains evt");
        access(0, 8'h08, 0, "R4 mains reg");
        // R9: event coinciding with clearing read
        access(0, 8'h00, 0, "R9 read with strobe", 0, 1);
        access(0, 8'h00, 0, "R9 kept flag");
        // R10: errors change nothing
        access(1, 8'h18, 32'h5, "R10 ro write");
        access(1, 8'h06, 32'h0, "R10 unaligned write");
        access(0, 8'h1C, 0, "R10 undefined read");
        access(0, 8'h05, 0, "R10 unaligned read");
        access(0, 8'h04, 0, "R10 enable unchanged");
        access(0, 8'h18, 0, "R10 level unchanged");
        // R11: idle cycle has no ack
        @(negedge clk);
        chk("R11 idle no ack", 32'(bus_ack), 0);
        // random mix, R1
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: batt_event(2'($urandom), 3'($urandom % 6), 1'($urandom), 7'($urandom), "R4 rand");
                1: mains_event(1'($urandom), "R4 rand mains");
                2: access(1, ($urandom % 2) ? 8'h04 : 8'($urandom), $urandom, "R6 rand write");
                3: access(0, 8'(($urandom % 8) * 4), 0, "R1 rand read");
                4: access(0, 8'($urandom), 0, "R10 rand read");
                default: access(0, 8'h00, 0, "R8 rand status", 1'($urandom), 1'($urandom));
            endcase
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule